// File: doc/BRIEF.md
# Power-Mode Sequencer with Idle Clock Gating

This block decides which clock domains of a small SoC run at any moment. In normal operation it keeps every domain clocked and reports run or turbo mode, following a turbo select input. On an idle request it stops only the CPU clock. While idle it watches the interrupt lines and wakes the CPU on a qualifying one. A control bit chooses the qualification rule. Either every interrupt enabled at its source wakes the CPU, or the interrupt must also be unmasked.

Two active-low supply-fault pins pass through a two-stage synchronizer. A second control bit sets what a fault does. It either forces the block into a sleep state that only reset leaves, or it raises a fault interrupt that wakes the CPU like any other interrupt. A frequency-change request stops the CPU, memory, display and DMA clocks for a programmable number of cycles, then restores them and returns to run mode. The peripheral clocks keep running throughout.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `rst_ni` is low and on the first edge after its release, `mode_o` is 0 (run), every bit of `clk_en_o` is 1, and `sleep_o` and `fault_irq_o` are 0. Reset is asynchronous.
- R2: In run (0) or turbo (1), `idle_req_i` moves `mode_o` to idle (2) on the next edge. In idle, `clk_en_o` bit 0 (CPU) is 0 and all other bits are 1.
- R3: With `mask_dis_i`=0, an interrupt whose `irq_i` and `irq_en_i` bits are both 1 wakes the block from idle on the next edge. `irq_unmask_i` has no effect on this.
- R4: With `mask_dis_i`=1, a wake needs `irq_i`, `irq_en_i` and `irq_unmask_i` all 1 on the same line. An enabled interrupt that is masked (unmask bit 0) leaves the block in idle.
- R5: An interrupt whose enable bit is 0 never wakes the block from idle.
- R6: On wake from idle, and on every edge in run or turbo with no request pending, `mode_o` becomes 1 (turbo) if `turbo_i` is 1 and 0 (run) otherwise.
- R7: The fault pins act through two synchronizer flops. A pin driven low just after edge E first takes effect on the mode at edge E+3. `fault_irq_o` reflects it from edge E+2.
- R8: With `fault_abort_en_i`=0, a synchronized fault in any mode other than sleep moves `mode_o` to sleep (4) on the next edge. `sleep_o` is 1 for exactly that first cycle, and every bit of `clk_en_o` is 0 while in sleep.
- R9: With `fault_abort_en_i`=1, `fault_irq_o` is 1 while a synchronized fault is present. In idle this fault wakes the block as an interrupt would. In run it does not change the mode.
- R10: Sleep is left only by reset. Requests, interrupts and released fault pins leave `mode_o` at 4.
- R11: A frequency-change request in run or turbo moves `mode_o` to 3 and captures `lock_cnt_i`. The mode stays 3 for `lock_cnt_i`+1 cycles and then becomes 0. While in mode 3, `clk_en_o` bits 0 to 3 (CPU, memory, display, DMA) are 0 and the peripheral bits above them are 1.
- R12: Idle and frequency-change requests are ignored outside run and turbo. When both are present together, idle wins.
- R13: Asserting `rst_ni` from idle or sleep sets `mode_o` to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_IRQ | Interrupt request lines |
| irq_en_i | input | NUM_IRQ | Per-source enable at the unit |
| irq_unmask_i | input | NUM_IRQ | Per-source unmask bit (1 = unmasked) |
| mask_dis_i | input | 1 | 1: idle wake also needs the unmask bit |
| fault_abort_en_i | input | 1 | 1: a fault becomes an interrupt; 0: a fault forces sleep |
| turbo_i | input | 1 | Selects turbo over run for the active mode |
| batt_flt_ni | input | 1 | Battery fault pin, active low, asynchronous |
| vdd_flt_ni | input | 1 | Core supply fault pin, active low, asynchronous |
| idle_req_i | input | 1 | Idle entry request |
| fcs_req_i | input | 1 | Frequency-change request |
| lock_cnt_i | input | LOCK_W | Lock wait length for a frequency change |
| clk_en_o | output | 4+NUM_PERIPH | Domain enables: 0 CPU, 1 memory, 2 display, 3 DMA, 4 and above peripherals |
| sleep_o | output | 1 | One-cycle strobe on entry to sleep |
| fault_irq_o | output | 1 | Fault interrupt |
| mode_o | output | 3 | 0 run, 1 turbo, 2 idle, 3 frequency change, 4 sleep |

## Verification
The bench aims at the wake rule under both settings of the mask-disable bit. An enabled but masked interrupt tells a design that ignores the mask bit apart from one that applies it when it should not. A disabled interrupt catches a design that wakes on raw requests. Fault pins are timed edge by edge. A missing or extra synchronizer stage shows up as a mode change one cycle off, and a swapped abort-enable polarity sends the block to sleep instead of waking it. Frequency-change length is checked for lock counts of three and zero to catch off-by-one counters. Requests issued in idle, in frequency change and in sleep must leave the mode unchanged.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [2:0] {
    MODE_RUN   = 3'd0,
    MODE_TURBO = 3'd1,
    MODE_IDLE  = 3'd2,
    MODE_FCS   = 3'd3,
    MODE_SLEEP = 3'd4
  } mode_e;

  localparam int DOM_CPU      = 0;
  localparam int DOM_MEM      = 1;
  localparam int DOM_DISP     = 2;
  localparam int DOM_DMA      = 3;
  localparam int NUM_CORE_DOM = 4;
endpackage

// File: rtl/pwr_fault_sync.sv
module pwr_fault_sync #(
  parameter int NUM_PIN = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_PIN-1:0] pin_ni,
  output logic               flt_o
);
  logic [NUM_PIN-1:0] stage1_q, stage2_q;

  for (genvar g = 0; g < NUM_PIN; g++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage1_q[g] <= 1'b1;
        stage2_q[g] <= 1'b1;
      end else begin
        stage1_q[g] <= pin_ni[g];
        stage2_q[g] <= stage1_q[g];
      end
    end
  end

  assign flt_o = ~&stage2_q;
endmodule

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual #(
  parameter int NUM_IRQ = 8
) (
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  input  logic [NUM_IRQ-1:0] irq_unmask_i,
  input  logic               mask_dis_i,
  input  logic               flt_i,
  input  logic               abort_en_i,
  output logic               wake_o,
  output logic               fault_irq_o,
  output logic               fault_sleep_o
);
  logic [NUM_IRQ-1:0] allow;

  // mask only applies in strict mode
  assign allow         = mask_dis_i ? irq_unmask_i : {NUM_IRQ{1'b1}};
  assign fault_irq_o   = flt_i & abort_en_i;
  assign fault_sleep_o = flt_i & ~abort_en_i;
  assign wake_o        = (|(irq_i & irq_en_i & allow)) | fault_irq_o;
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
#(
  parameter int LOCK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              turbo_i,
  input  logic              idle_req_i,
  input  logic              fcs_req_i,
  input  logic [LOCK_W-1:0] lock_cnt_i,
  input  logic              wake_i,
  input  logic              fault_sleep_i,
  output mode_e             mode_o,
  output logic              sleep_o
);
  mode_e             mode_q, mode_d;
  logic [LOCK_W-1:0] cnt_q, cnt_d;
  logic              sleep_q;
  mode_e             active_mode;

  assign active_mode = turbo_i ? MODE_TURBO : MODE_RUN;

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    unique case (mode_q)
      MODE_RUN, MODE_TURBO: begin
        if (idle_req_i) begin
          mode_d = MODE_IDLE;
        end else if (fcs_req_i) begin
          mode_d = MODE_FCS;
          cnt_d  = lock_cnt_i;
        end else begin
          mode_d = active_mode;
        end
      end
      MODE_IDLE: if (wake_i) mode_d = active_mode;
      MODE_FCS: begin
        if (cnt_q == '0) mode_d = MODE_RUN;
        else             cnt_d  = cnt_q - 1'b1;
      end
      MODE_SLEEP: mode_d = MODE_SLEEP;
      default:    mode_d = MODE_RUN;
    endcase
    if (fault_sleep_i && mode_q != MODE_SLEEP) mode_d = MODE_SLEEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_RUN;
      cnt_q   <= '0;
      sleep_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      cnt_q   <= cnt_d;
      sleep_q <= (mode_d == MODE_SLEEP) && (mode_q != MODE_SLEEP);
    end
  end

  assign mode_o  = mode_q;
  assign sleep_o = sleep_q;
endmodule

// File: rtl/pwr_clk_en_dec.sv
module pwr_clk_en_dec
  import pwr_mode_pkg::*;
#(
  parameter int NUM_PERIPH = 2,
  localparam int NUM_DOM   = NUM_CORE_DOM + NUM_PERIPH
) (
  input  mode_e              mode_i,
  output logic [NUM_DOM-1:0] clk_en_o
);
  logic cpu_on, core_on, periph_on;

  assign cpu_on    = (mode_i == MODE_RUN) || (mode_i == MODE_TURBO);
  assign core_on   = (mode_i != MODE_FCS) && (mode_i != MODE_SLEEP);
  assign periph_on = (mode_i != MODE_SLEEP);

  assign clk_en_o[DOM_CPU]  = cpu_on;
  assign clk_en_o[DOM_MEM]  = core_on;
  assign clk_en_o[DOM_DISP] = core_on;
  assign clk_en_o[DOM_DMA]  = core_on;

  for (genvar g = NUM_CORE_DOM; g < NUM_DOM; g++) begin : g_periph
    assign clk_en_o[g] = periph_on;
  end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int NUM_IRQ    = 8,
  parameter int NUM_PERIPH = 2,
  parameter int LOCK_W     = 8,
  localparam int NUM_DOM   = NUM_CORE_DOM + NUM_PERIPH
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  input  logic [NUM_IRQ-1:0] irq_unmask_i,
  input  logic               mask_dis_i,
  input  logic               fault_abort_en_i,
  input  logic               turbo_i,
  input  logic               batt_flt_ni,
  input  logic               vdd_flt_ni,
  input  logic               idle_req_i,
  input  logic               fcs_req_i,
  input  logic [LOCK_W-1:0]  lock_cnt_i,
  output logic [NUM_DOM-1:0] clk_en_o,
  output logic               sleep_o,
  output logic               fault_irq_o,
  output logic [2:0]         mode_o
);
  logic  flt_w, wake_w, fault_sleep_w;
  mode_e mode_w;

  pwr_fault_sync #(.NUM_PIN(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_ni ({vdd_flt_ni, batt_flt_ni}),
    .flt_o  (flt_w)
  );

  pwr_wake_qual #(.NUM_IRQ(NUM_IRQ)) u_qual (
    .irq_i         (irq_i),
    .irq_en_i      (irq_en_i),
    .irq_unmask_i  (irq_unmask_i),
    .mask_dis_i    (mask_dis_i),
    .flt_i         (flt_w),
    .abort_en_i    (fault_abort_en_i),
    .wake_o        (wake_w),
    .fault_irq_o   (fault_irq_o),
    .fault_sleep_o (fault_sleep_w)
  );

  pwr_mode_fsm #(.LOCK_W(LOCK_W)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .turbo_i       (turbo_i),
    .idle_req_i    (idle_req_i),
    .fcs_req_i     (fcs_req_i),
    .lock_cnt_i    (lock_cnt_i),
    .wake_i        (wake_w),
    .fault_sleep_i (fault_sleep_w),
    .mode_o        (mode_w),
    .sleep_o       (sleep_o)
  );

  pwr_clk_en_dec #(.NUM_PERIPH(NUM_PERIPH)) u_dec (
    .mode_i   (mode_w),
    .clk_en_o (clk_en_o)
  );

  assign mode_o = mode_w;
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk #(
  parameter int NUM_IRQ = 8,
  parameter int NUM_DOM = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [2:0]         mode_i,
  input logic [NUM_DOM-1:0] clk_en_i,
  input logic               sleep_i,
  input logic [NUM_IRQ-1:0] irq_i,
  input logic [NUM_IRQ-1:0] irq_en_i,
  input logic               mask_dis_i,
  input logic               abort_en_i,
  input logic               flt_i
);
  p_idle_dom_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 3'd2 |-> (clk_en_i == {{(NUM_DOM-1){1'b1}}, 1'b0}));

  p_loose_wake_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd2 && !flt_i && !mask_dis_i && |(irq_i & irq_en_i))
    |=> (mode_i == 3'd0 || mode_i == 3'd1));

  p_no_wake_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd2 && !flt_i && !(|(irq_i & irq_en_i))) |=> mode_i == 3'd2);

  p_fault_sleep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_i && !abort_en_i && mode_i != 3'd4) |=> (mode_i == 3'd4 && sleep_i));

  p_sleep_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !sleep_i);

  p_sleep_dom_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 3'd4 |-> clk_en_i == '0);

  p_sleep_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 3'd4 |=> mode_i == 3'd4);

  p_fcs_dom_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 3'd3 |-> (clk_en_i[3:0] == 4'h0 && &clk_en_i[NUM_DOM-1:4]));

  p_mode_legal_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i <= 3'd4);
endmodule

bind pwr_mode_seq pwr_mode_chk #(.NUM_IRQ(NUM_IRQ), .NUM_DOM(NUM_DOM)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_o),
  .clk_en_i   (clk_en_o),
  .sleep_i    (sleep_o),
  .irq_i      (irq_i),
  .irq_en_i   (irq_en_i),
  .mask_dis_i (mask_dis_i),
  .abort_en_i (fault_abort_en_i),
  .flt_i      (flt_w)
);

// File: tb/tb_pwr_mode_seq.sv
`timescale 1ns/1ps
module tb_pwr_mode_seq;
  localparam int NI = 8;
  localparam int ND = 6;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NI-1:0] irq_i = '0, irq_en_i = '0, irq_unmask_i = '0;
  logic          mask_dis_i = 1'b0, fault_abort_en_i = 1'b0, turbo_i = 1'b0;
  logic          batt_flt_ni = 1'b1, vdd_flt_ni = 1'b1;
  logic          idle_req_i = 1'b0, fcs_req_i = 1'b0;
  logic [7:0]    lock_cnt_i = '0;
  logic [ND-1:0] clk_en_o;
  logic          sleep_o, fault_irq_o;
  logic [2:0]    mode_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk_i = ~clk_i;

  pwr_mode_seq dut (.*);

  task automatic step(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic defaults();
    irq_i = '0; irq_en_i = '0; irq_unmask_i = '0;
    mask_dis_i = 0; fault_abort_en_i = 0; turbo_i = 0;
    batt_flt_ni = 1; vdd_flt_ni = 1; idle_req_i = 0; fcs_req_i = 0; lock_cnt_i = '0;
  endtask

  task automatic t_reset();
    defaults();
    rst_ni = 0;
    #1;
    chk("R1 mode in reset", mode_o, 0);
    chk("R1 enables in reset", clk_en_o, 6'h3F);
    step(2);
    rst_ni = 1;
    step(1);
    chk("R1 mode", mode_o, 0);
    chk("R1 enables", clk_en_o, 6'h3F);
    chk("R1 sleep", sleep_o, 0);
    chk("R1 fault irq", fault_irq_o, 0);
  endtask

  task automatic enter_idle();
    idle_req_i = 1;
    step(1);
    idle_req_i = 0;
    chk("R2 idle mode", mode_o, 2);
    chk("R2 idle enables", clk_en_o, 6'h3E);
  endtask

  task automatic t_loose_wake();
    t_reset();
    irq_en_i = 8'h04;
    enter_idle();
    step(2);
    chk("R2 stays idle", mode_o, 2);
    irq_i = 8'h04;
    step(1);
    chk("R3 wake with mask ignored", mode_o, 0);
    irq_i = '0;
    turbo_i = 1;
    step(1);
    chk("R6 turbo in active", mode_o, 1);
    enter_idle();
    irq_i = 8'h04;
    step(1);
    chk("R6 wake into turbo", mode_o, 1);
    irq_i = '0;
  endtask

  task automatic t_strict_wake();
    t_reset();
    mask_dis_i = 1;
    irq_en_i = 8'h10;
    enter_idle();
    irq_i = 8'h10;
    step(2);
    chk("R4 masked enabled no wake", mode_o, 2);
    irq_unmask_i = 8'h10;
    step(1);
    chk("R4 unmasked wake", mode_o, 0);
    irq_i = '0;
  endtask

  task automatic t_not_enabled();
    t_reset();
    irq_unmask_i = 8'hFF;
    enter_idle();
    irq_i = 8'hFF;
    step(3);
    chk("R5 disabled irq no wake", mode_o, 2);
    irq_en_i = 8'h01;
    step(1);
    chk("R5 enable then wake", mode_o, 0);
    irq_i = '0;
  endtask

  task automatic t_fault_sleep();
    t_reset();
    enter_idle();
    batt_flt_ni = 0;
    step(2);
    chk("R7 not yet acted", mode_o, 2);
    chk("R7 no strobe yet", sleep_o, 0);
    step(1);
    chk("R8 sleep mode", mode_o, 4);
    chk("R8 strobe", sleep_o, 1);
    chk("R8 enables off", clk_en_o, 0);
    step(1);
    chk("R8 strobe one cycle", sleep_o, 0);
    batt_flt_ni = 1;
    idle_req_i = 1; fcs_req_i = 1; irq_en_i = '1; irq_i = '1;
    step(4);
    chk("R10 sleep sticky", mode_o, 4);
    chk("R10 enables stay off", clk_en_o, 0);
    defaults();
    #0.5 rst_ni = 0;
    #0.5;
    chk("R13 async reset from sleep", mode_o, 0);
    step(1);
    rst_ni = 1;
    step(1);
    enter_idle();
    #0.5 rst_ni = 0;
    #0.5;
    chk("R13 async reset from idle", mode_o, 0);
    step(1);
    rst_ni = 1;
    step(1);
  endtask

  task automatic t_fault_run_sleep();
    t_reset();
    vdd_flt_ni = 0;
    step(3);
    chk("R8 fault in run sleeps", mode_o, 4);
    vdd_flt_ni = 1;
  endtask

  task automatic t_fault_irq();
    t_reset();
    fault_abort_en_i = 1;
    enter_idle();
    vdd_flt_ni = 0;
    step(1);
    chk("R7 irq after one stage", fault_irq_o, 0);
    step(1);
    chk("R9 fault irq", fault_irq_o, 1);
    chk("R9 still idle", mode_o, 2);
    step(1);
    chk("R9 fault wake", mode_o, 0);
    step(2);
    chk("R9 run unaffected", mode_o, 0);
    vdd_flt_ni = 1;
    step(2);
    chk("R9 irq clears", fault_irq_o, 0);
  endtask

  task automatic t_fcs();
    t_reset();
    lock_cnt_i = 8'd3;
    fcs_req_i = 1;
    step(1);
    fcs_req_i = 0;
    lock_cnt_i = 8'd9;
    chk("R11 fcs mode", mode_o, 3);
    chk("R11 fcs enables", clk_en_o, 6'h30);
    idle_req_i = 1;
    step(3);
    chk("R12 idle ignored in fcs", mode_o, 3);
    idle_req_i = 0;
    step(1);
    chk("R11 back to run", mode_o, 0);
    chk("R11 enables restored", clk_en_o, 6'h3F);
    lock_cnt_i = 8'd0;
    fcs_req_i = 1;
    step(1);
    fcs_req_i = 0;
    chk("R11 zero lock enters", mode_o, 3);
    step(1);
    chk("R11 zero lock one cycle", mode_o, 0);
  endtask

  task automatic t_req_priority();
    t_reset();
    idle_req_i = 1; fcs_req_i = 1;
    step(1);
    idle_req_i = 0;
    chk("R12 idle wins", mode_o, 2);
    step(2);
    chk("R12 fcs ignored in idle", mode_o, 2);
    fcs_req_i = 0;
  endtask

  initial begin
    t_reset();
    t_loose_wake();
    t_strict_wake();
    t_not_enabled();
    t_fault_sleep();
    t_fault_run_sleep();
    t_fault_irq();
    t_fcs();
    t_req_priority();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule